// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

A 32-pin general-purpose I/O port controlled through a simple 32-bit register bus. The bus has an address, a write enable, write data and combinational read data. Software sets an output data value and a per-pin direction. It reads the synchronised pad levels from a read-only register.

Every pin has its own interrupt detector. The detector can trigger on a low level, a high level, a rising edge or a falling edge, or on both edges when the pin's dual-edge bit is set. A detection sets a sticky status bit, and software clears that bit by writing 1 to it. A mask register gates the status bits onto two interrupt lines: one for pins 0 to 15 and one for pins 16 to 31.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is held, every register reads 0, `pad_oe_o` is 0 and both interrupt outputs are 0.
- R2: The register at offset 0x00 holds output data and offset 0x04 holds direction. `pad_oe_o` equals the direction register and `pad_o` equals the output data register. A read of 0x00 returns the last value written there, never the pad level.
- R3: Offset 0x08 returns the pad inputs after a two-flop synchroniser. Writes to 0x08 have no effect.
- R4: Pin n's 2-bit trigger field lies at bits [2(n mod 16)+1 : 2(n mod 16)]. For pins 0 to 15 it is in the register at 0x0C, and for pins 16 to 31 it is in the register at 0x10.
- R5: Field value 0 selects low level and 1 selects high level. While the level holds, the status bit is set again on every clock. Once the level is gone, a clear leaves the bit at 0.
- R6: Field value 2 selects rising edge and 3 selects falling edge. Each sets the status bit once per matching transition and ignores the opposite transition.
- R7: When a pin's bit at offset 0x1C is 1, that pin detects both rising and falling edges and its trigger field is ignored.
- R8: Offset 0x18 is the status register. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: If a clear and a new detection fall on the same bit in the same cycle, the bit stays set.
- R10: Offset 0x14 is the mask, where 1 enables a pin. `irq_lo_o` is the OR of (status AND mask) over pins 0 to 15. `irq_hi_o` is the same OR over pins 16 to 31.
- R11: A pad transition that is applied before clock edge k becomes visible in the status register after edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| pad_i | input | 32 | Pad input levels |
| pad_o | output | 32 | Pad output data |
| pad_oe_o | output | 32 | Pad output enables |
| irq_lo_o | output | 1 | Interrupt for pins 0 to 15 |
| irq_hi_o | output | 1 | Interrupt for pins 16 to 31 |

## Verification
A write-1 clear of a status bit can land in the same cycle as a new detection on that pin.

The bench provokes this collision on a pin configured for high level while its pad is held high. It issues the clear and samples the status register in the very cycle the write takes effect, before another edge could set the bit again. The result is judged correct only if the bit reads as set.

The same clear is repeated after the pad level has dropped, where the bit must then read 0.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_AW = 8;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  localparam logic [REG_AW-1:0] OFS_DOUT   = 8'h00;
  localparam logic [REG_AW-1:0] OFS_DIR    = 8'h04;
  localparam logic [REG_AW-1:0] OFS_PAD    = 8'h08;
  localparam logic [REG_AW-1:0] OFS_CFG_LO = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_CFG_HI = 8'h10;
  localparam logic [REG_AW-1:0] OFS_MASK   = 8'h14;
  localparam logic [REG_AW-1:0] OFS_STAT   = 8'h18;
  localparam logic [REG_AW-1:0] OFS_BOTH   = 8'h1C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_det.sv
module gpio_pin_det
  import gpio_irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  input  trig_e trig_i,
  input  logic  both_i,
  output logic  det_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    if (both_i) det_o = rise | fall;
    else begin
      unique case (trig_i)
        TRIG_LOW:  det_o = ~lvl_i;
        TRIG_HIGH: det_o = lvl_i;
        TRIG_RISE: det_o = rise;
        TRIG_FALL: det_o = fall;
        default:   det_o = 1'b0;
      endcase
    end
  end

  AST_RISE_DETECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!both_i && trig_i == TRIG_RISE && $rose(lvl_i)) |-> det_o); // R6
  AST_FALL_DETECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!both_i && trig_i == TRIG_FALL && $fell(lvl_i)) |-> det_o); // R6
  AST_BOTH_EDGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both_i && !$stable(lvl_i)) |-> det_o); // R7
  AST_BOTH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both_i && $stable(lvl_i)) |-> !det_o); // R7
endmodule

// File: rtl/gpio_irq_stat.sv
module gpio_irq_stat #(
  parameter int unsigned W = 32,
  localparam int unsigned HALF = W / 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] det_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] stat_o,
  output logic         irq_lo_o,
  output logic         irq_hi_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] pend;

  // detection wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | det_i;
  end

  assign pend     = stat_q & mask_i;
  assign irq_lo_o = |pend[HALF-1:0];
  assign irq_hi_o = |pend[W-1:HALF];
  assign stat_o   = stat_q;

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(clr_i) & ~$past(det_i)) == '0)); // R8
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~stat_q & $past(stat_q) & ~$past(clr_i)) == '0)); // R8
  AST_DET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~stat_q & $past(det_i)) == '0)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> (!irq_lo_o && !irq_hi_o)); // R10
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = REG_AW,
  localparam int unsigned HALF = DW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pad_i,
  output logic [DW-1:0] pad_o,
  output logic [DW-1:0] pad_oe_o,
  output logic          irq_lo_o,
  output logic          irq_hi_o
);
  logic [DW-1:0] dout_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, both_q;
  logic [DW-1:0] pad_s, det, stat, clr;
  logic sel_dout, sel_dir, sel_cfg_lo, sel_cfg_hi, sel_mask, sel_stat, sel_both;

  assign sel_dout   = addr_i == AW'(OFS_DOUT);
  assign sel_dir    = addr_i == AW'(OFS_DIR);
  assign sel_cfg_lo = addr_i == AW'(OFS_CFG_LO);
  assign sel_cfg_hi = addr_i == AW'(OFS_CFG_HI);
  assign sel_mask   = addr_i == AW'(OFS_MASK);
  assign sel_stat   = addr_i == AW'(OFS_STAT);
  assign sel_both   = addr_i == AW'(OFS_BOTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      both_q   <= '0;
    end else if (we_i) begin
      if (sel_dout)   dout_q   <= wdata_i;
      if (sel_dir)    dir_q    <= wdata_i;
      if (sel_cfg_lo) cfg_lo_q <= wdata_i;
      if (sel_cfg_hi) cfg_hi_q <= wdata_i;
      if (sel_mask)   mask_q   <= wdata_i;
      if (sel_both)   both_q   <= wdata_i;
    end
  end

  assign clr = (we_i && sel_stat) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    unique case (1'b1)
      sel_dout:                    rdata_o = dout_q;
      sel_dir:                     rdata_o = dir_q;
      addr_i == AW'(OFS_PAD):      rdata_o = pad_s;
      sel_cfg_lo:                  rdata_o = cfg_lo_q;
      sel_cfg_hi:                  rdata_o = cfg_hi_q;
      sel_mask:                    rdata_o = mask_q;
      sel_stat:                    rdata_o = stat;
      sel_both:                    rdata_o = both_q;
      default:                     rdata_o = '0;
    endcase
  end

  assign pad_o    = dout_q;
  assign pad_oe_o = dir_q;

  gpio_sync #(.W(DW), .STAGES(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pad_s)
  );

  for (genvar n = 0; n < DW; n++) begin : g_pin
    logic [1:0] fld;
    if (n < HALF) begin : g_lo
      assign fld = cfg_lo_q[2*n +: 2];
    end else begin : g_hi
      assign fld = cfg_hi_q[2*(n-HALF) +: 2];
    end
    gpio_pin_det i_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (pad_s[n]),
      .trig_i(trig_e'(fld)),
      .both_i(both_q[n]),
      .det_o (det[n])
    );
  end

  gpio_irq_stat #(.W(DW)) i_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .det_i   (det),
    .clr_i   (clr),
    .mask_i  (mask_q),
    .stat_o  (stat),
    .irq_lo_o(irq_lo_o),
    .irq_hi_o(irq_hi_o)
  );

  AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel_dout) |=> $stable(pad_o)); // R2
  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel_dir) |=> $stable(pad_oe_o)); // R2
endmodule

// File: tb/test_gpio_irq_port.sv
`timescale 1ns/1ps
module test_gpio_irq_port;
  localparam logic [7:0] A_DOUT = 8'h00, A_DIR = 8'h04, A_PAD = 8'h08, A_CLO = 8'h0C,
                         A_CHI = 8'h10, A_MASK = 8'h14, A_STAT = 8'h18, A_BOTH = 8'h1C;

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // write then read back; pad register ignores the write (pads are 0)
  localparam vec_t VEC [0:7] = '{
    '{A_DOUT, 32'hA5A5_0F0F, 32'hA5A5_0F0F, 4'd2},
    '{A_DIR,  32'h0000_FFFF, 32'h0000_FFFF, 4'd2},
    '{A_MASK, 32'h0000_0000, 32'h0000_0000, 4'd10},
    '{A_BOTH, 32'h0000_0000, 32'h0000_0000, 4'd7},
    '{A_CLO,  32'hAAAA_AAAA, 32'hAAAA_AAAA, 4'd4},
    '{A_CHI,  32'hAAAA_AAAA, 32'hAAAA_AAAA, 4'd4},
    '{A_PAD,  32'hFFFF_FFFF, 32'h0000_0000, 4'd3},
    '{A_DOUT, 32'h0F0F_5A5A, 32'h0F0F_5A5A, 4'd2}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pad_i = '0;
  logic [31:0] pad_o, pad_oe;
  logic        irq_lo, irq_hi;
  int          n_cmp = 0, n_bad = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  gpio_irq_port i_gpio_irq_port (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_i(pad_i), .pad_o(pad_o), .pad_oe_o(pad_oe),
    .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b0;
    #0.5 d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state, sampled while reset is held
    wait_n(2);
    for (int i = 0; i < 8; i++) begin
      addr = 8'(i * 4); #0.5;
      chk("R1 reg", rdata, 32'h0);
    end
    chk("R1 oe", pad_oe, 32'h0);
    chk("R1 irq", {30'h0, irq_hi, irq_lo}, 32'h0);
    @(negedge clk); rst_ni = 1'b1;

    // all pins rising edge, then flush low-level detections
    wr(A_CLO, 32'hAAAA_AAAA);
    wr(A_CHI, 32'hAAAA_AAAA);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, rv); chk("R8 clear all", rv, 32'h0);

    foreach (VEC[i]) begin
      wr(VEC[i].addr, VEC[i].wdata);
      rd(VEC[i].addr, rv);
      n_cmp++;
      if (rv !== VEC[i].exp) begin
        n_bad++;
        $display("FAIL R%0d vec %0d: actual %h expected %h", VEC[i].req, i, rv, VEC[i].exp);
      end
    end
    chk("R2 pad_o", pad_o, 32'h0F0F_5A5A);
    chk("R2 pad_oe", pad_oe, 32'h0000_FFFF);

    // R2 R3 R6: pad pattern rising
    @(negedge clk); pad_i = 32'h1234_5678;
    wait_n(3);
    rd(A_DOUT, rv); chk("R2 dout not pad", rv, 32'h0F0F_5A5A);
    rd(A_PAD, rv);  chk("R3 pad status", rv, 32'h1234_5678);
    rd(A_STAT, rv); chk("R6 rising set", rv, 32'h1234_5678);
    @(negedge clk); pad_i = 32'h0;
    wait_n(3);
    rd(A_STAT, rv); chk("R6 falling ignored", rv, 32'h1234_5678);
    wr(A_STAT, 32'h0);
    rd(A_STAT, rv); chk("R8 write 0 keeps", rv, 32'h1234_5678);
    wr(A_STAT, 32'h1234_5678);
    rd(A_STAT, rv); chk("R8 write 1 clears", rv, 32'h0);

    // R11: latency of pin 3 rising
    @(negedge clk); pad_i = 32'h8;
    rd(A_STAT, rv); chk("R11 edge+1", rv, 32'h0);
    rd(A_STAT, rv); chk("R11 edge+2", rv, 32'h0);
    rd(A_STAT, rv); chk("R11 edge+3", rv, 32'h8);
    wr(A_MASK, 32'h8);
    chk("R10 lo pending", {30'h0, irq_hi, irq_lo}, 32'h1);

    // R6 falling on pin 3 (bits 7:6 = 3)
    wr(A_CLO, 32'hAAAA_AAEA);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, rv); chk("R6 no event", rv, 32'h0);
    chk("R10 lo idle", {30'h0, irq_hi, irq_lo}, 32'h0);
    @(negedge clk); pad_i = 32'h0;
    wait_n(3);
    rd(A_STAT, rv); chk("R6 falling set", rv, 32'h8);
    chk("R10 lo again", {30'h0, irq_hi, irq_lo}, 32'h1);

    // R9 R5 R10: pin 20 high level (hi reg bits 9:8 = 1)
    wr(A_CHI, 32'hAAAA_A9AA);
    wr(A_MASK, 32'h0010_0000);
    wr(A_STAT, 32'hFFFF_FFFF);
    @(negedge clk); pad_i = 32'h0010_0000;
    wait_n(3);
    rd(A_STAT, rv); chk("R5 high level", rv, 32'h0010_0000);
    chk("R10 hi pending", {30'h0, irq_hi, irq_lo}, 32'h2);
    wr(A_STAT, 32'h0010_0000);
    #0.5 chk("R9 clear vs detect", rdata, 32'h0010_0000);
    @(negedge clk); pad_i = 32'h0;
    wait_n(3);
    wr(A_STAT, 32'h0010_0000);
    rd(A_STAT, rv); chk("R5 level gone", rv, 32'h0);
    chk("R10 hi idle", {30'h0, irq_hi, irq_lo}, 32'h0);

    // R4 R5: pin 1 low level (lo reg bits 3:2 = 0)
    wr(A_CLO, 32'hAAAA_AAE2);
    rd(A_STAT, rv); chk("R4 low level pin 1", rv, 32'h2);
    wr(A_CLO, 32'hAAAA_AAEA);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, rv); chk("R5 cleared", rv, 32'h0);

    // R7: pin 5 dual edge, field set to low level but ignored
    wr(A_BOTH, 32'h20);
    wr(A_CLO, 32'hAAAA_A2EA);
    wr(A_STAT, 32'hFFFF_FFFF);
    wait_n(2);
    rd(A_STAT, rv); chk("R7 field ignored", rv, 32'h0);
    @(negedge clk); pad_i = 32'h20;
    wait_n(3);
    rd(A_STAT, rv); chk("R7 rise", rv, 32'h20);
    wr(A_STAT, 32'h20);
    rd(A_STAT, rv); chk("R7 cleared", rv, 32'h0);
    @(negedge clk); pad_i = 32'h0;
    wait_n(3);
    rd(A_STAT, rv); chk("R7 fall", rv, 32'h20);
    wr(A_MASK, 32'h0);
    chk("R10 masked", {30'h0, irq_hi, irq_lo}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule